// File: doc/BRIEF.md
# Video Memory Cycle Scheduler

The block shares one memory port between four users: reads that fill the display row buffer, reads of user-defined character slices, indirect accesses made on behalf of the CPU, and DRAM refresh. It does not arbitrate dynamically. A fixed pattern, tied to the video raster, decides what every memory cycle does. Two memory cycles make one slot. A scan line has an active part of `ACT_SLOTS` slots followed by a blanking part of `BLK_SLOTS` slots. A frame has `FRAME_LINES` lines. The first `ACTIVE_LINES` of them show characters, in rows of `ROW_LINES` lines each.

Internal counters track the cycle within the slot, the slot within the line, the line within the frame, and the line within the character row. From these the block classifies each line. Lines that show characters are first row lines, last row lines or other row lines. All remaining lines are inactive. For every memory cycle the block outputs the cycle type and a grant for a pending CPU request. It also outputs the refresh row address, which steps after each refresh cycle. A CPU request that arrives while CPU cycles are blocked is held until the next slot that offers one.

Top module: `vms_cycle_sched`

## Requirements
- R1: Cycle type codes are dummy = 0, CPU = 1, refresh = 2, slice = 3, load = 4. On the active part of the first and last line of a character row, the first cycle of each slot is a load and the second is a slice. Slot 0 is the exception: its first cycle is a dummy.
- R2: On the active part of any other line within a character row, the first cycle of each slot is a slice and the second is a CPU opportunity.
- R3: In the blanking part of every line, and on every inactive line, the first cycle of each slot is a refresh and the second is a CPU opportunity.
- R4: `cpu_grant` is high only in a CPU opportunity cycle, and it is high exactly when the cycle type is CPU. This limits the CPU to at most one access per slot.
- R5: A request (`cpu_req` high in a cycle) is granted in that same cycle if the cycle is a CPU opportunity. Otherwise it is held and granted in the next CPU opportunity cycle. Requests that arrive while one is already held merge with it.
- R6: A CPU opportunity cycle with no held request and no new request has type dummy, and `cpu_grant` stays low.
- R7: `ref_addr` increases by one, modulo 2^`REF_W`, on the clock edge that ends a refresh cycle. At every other edge it stays unchanged.
- R8: Counting starts from line 0 of a frame. The row-line index returns to the first line of a row every `ROW_LINES` display lines and at the start of each frame, so first, last and other lines repeat with period `ROW_LINES`.
- R9: While reset is asserted, the cycle type is dummy, `cpu_grant` is low and `ref_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock, one edge per memory cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU indirect access request, one cycle per request |
| cpu_grant | output | 1 | The current cycle serves the CPU |
| cyc_type | output | 3 | Type of the current memory cycle (codes in R1) |
| ref_addr | output | REF_W | Low address used by refresh cycles |

## Verification
A wrong slot or line counter moves the pattern. Within one slot, a load, slice or refresh appears where the raster arithmetic predicts a different type, and at a row or frame boundary the wrong line kind is applied to a whole line. A lost or stuck held-request flag shows at the next CPU opportunity: the cycle is either a missed grant typed dummy or a spurious grant. A bad refresh counter shows on the edge after the first refresh cycle it miscounts.

// File: rtl/vms_pkg.sv
package vms_pkg;

   typedef enum logic [2:0] {
      CYC_DUMMY   = 3'd0,
      CYC_CPU     = 3'd1,
      CYC_REFRESH = 3'd2,
      CYC_SLICE   = 3'd3,
      CYC_LOAD    = 3'd4
   } cyc_kind_e;

   typedef enum logic [1:0] {
      LN_INACTIVE = 2'd0,
      LN_FIRST    = 2'd1,
      LN_LAST     = 2'd2,
      LN_OTHER    = 2'd3
   } line_kind_e;

   // Width that holds values 0..max, never less than one bit.
   function automatic int cnt_width(input int max_val);
      int w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/vms_wrap_ctr.sv
module vms_wrap_ctr #(
   parameter int MAX_VAL = 7,
   parameter int W       = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_max
);
   initial begin
      assert (MAX_VAL >= 0) else $error("vms_wrap_ctr: MAX_VAL must be non-negative");
      assert ((MAX_VAL >> W) == 0) else $error("vms_wrap_ctr: W too narrow for MAX_VAL");
   end

   localparam logic [W-1:0] LAST = W'(MAX_VAL);

   generate
      if (MAX_VAL == 0) begin : g_const
         assign cnt    = '0;
         assign at_max = 1'b1;
      end else begin : g_count
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (en) begin
               if (cnt_q == LAST) cnt_q <= '0;
               else               cnt_q <= cnt_q + W'(1);
            end
         end
         assign cnt    = cnt_q;
         assign at_max = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/vms_timebase.sv
module vms_timebase
   import vms_pkg::*;
#(
   parameter int ACT_SLOTS    = 40,
   parameter int BLK_SLOTS    = 24,
   parameter int FRAME_LINES  = 312,
   parameter int ACTIVE_LINES = 250,
   parameter int ROW_LINES    = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       phase,
   output logic       slot_first,
   output logic       slot_active,
   output line_kind_e line_kind
);
   localparam int LINE_SLOTS = ACT_SLOTS + BLK_SLOTS;
   localparam int SLOT_W     = cnt_width(LINE_SLOTS - 1);
   localparam int LINE_W     = cnt_width(FRAME_LINES - 1);
   localparam int ROW_W      = cnt_width(ROW_LINES - 1);

   logic              phase_q;
   logic [SLOT_W-1:0] slot_cnt;
   logic              slot_wrap;
   logic [LINE_W-1:0] line_cnt;
   logic              line_wrap;
   logic [ROW_W-1:0]  row_cnt;
   logic              row_wrap;
   logic              line_end;
   logic              frame_end;
   logic              line_shown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= 1'b0;
      else        phase_q <= ~phase_q;
   end

   assign line_end  = phase_q & slot_wrap;
   assign frame_end = line_end & line_wrap;

   vms_wrap_ctr #(.MAX_VAL(LINE_SLOTS - 1), .W(SLOT_W)) i_slot_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .en     (phase_q),
      .cnt    (slot_cnt),
      .at_max (slot_wrap)
   );

   vms_wrap_ctr #(.MAX_VAL(FRAME_LINES - 1), .W(LINE_W)) i_line_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (1'b0),
      .en     (line_end),
      .cnt    (line_cnt),
      .at_max (line_wrap)
   );

   vms_wrap_ctr #(.MAX_VAL(ROW_LINES - 1), .W(ROW_W)) i_row_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (frame_end),
      .en     (line_end & line_shown),
      .cnt    (row_cnt),
      .at_max (row_wrap)
   );

   assign line_shown  = (32'(line_cnt) < ACTIVE_LINES);
   assign slot_active = (32'(slot_cnt) < ACT_SLOTS);
   assign slot_first  = (slot_cnt == '0);
   assign phase       = phase_q;

   always_comb begin
      if (!line_shown)           line_kind = LN_INACTIVE;
      else if (row_cnt == '0)    line_kind = LN_FIRST;
      else if (row_wrap)         line_kind = LN_LAST;
      else                       line_kind = LN_OTHER;
   end

endmodule

// File: rtl/vms_slot_decode.sv
module vms_slot_decode
   import vms_pkg::*;
(
   input  logic       phase,
   input  logic       slot_first,
   input  logic       slot_active,
   input  line_kind_e line_kind,
   output cyc_kind_e  fixed_kind,
   output logic       cpu_slot
);
   logic reload_line;

   assign reload_line = (line_kind == LN_FIRST) || (line_kind == LN_LAST);

   always_comb begin
      cpu_slot   = 1'b0;
      fixed_kind = CYC_DUMMY;
      if (slot_active && reload_line) begin
         if (!phase) fixed_kind = slot_first ? CYC_DUMMY : CYC_LOAD;
         else        fixed_kind = CYC_SLICE;
      end else if (slot_active && (line_kind == LN_OTHER)) begin
         if (!phase) fixed_kind = CYC_SLICE;
         else        cpu_slot   = 1'b1;
      end else begin
         if (!phase) fixed_kind = CYC_REFRESH;
         else        cpu_slot   = 1'b1;
      end
   end

endmodule

// File: rtl/vms_cpu_gate.sv
module vms_cpu_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_slot,
   input  logic req,
   output logic grant,
   output logic pend
);
   logic pend_q;
   logic want;

   assign want  = pend_q | req;
   assign grant = cpu_slot & want;
   assign pend  = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= want & ~grant;
   end

endmodule

// File: rtl/vms_refresh_ctr.sv
module vms_refresh_ctr #(
   parameter int REF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [REF_W-1:0] addr
);
   logic [REF_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (step) addr_q <= addr_q + REF_W'(1);
   end

   assign addr = addr_q;

endmodule

// File: rtl/vms_cycle_sched.sv
module vms_cycle_sched
   import vms_pkg::*;
#(
   parameter int ACT_SLOTS        = 40,
   parameter int BLK_SLOTS        = 24,
   parameter int FRAME_LINES      = 312,
   parameter int ACTIVE_LINES     = 250,
   parameter int ROW_LINES        = 10,
   parameter int REF_W            = 8,
   parameter int REF_PERIOD_SLOTS = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req,
   output logic             cpu_grant,
   output logic [2:0]       cyc_type,
   output logic [REF_W-1:0] ref_addr
);
   localparam int LINE_SLOTS    = ACT_SLOTS + BLK_SLOTS;
   localparam int REF_STATES    = 1 << REF_W;
   localparam int LINES_PER_REF = (REF_STATES + BLK_SLOTS - 1) / (BLK_SLOTS > 0 ? BLK_SLOTS : 1);

   initial begin
      assert (ACT_SLOTS > 0)  else $error("vms_cycle_sched: ACT_SLOTS must be positive");
      assert (BLK_SLOTS > 0)  else $error("vms_cycle_sched: BLK_SLOTS must be positive");
      assert (ROW_LINES >= 2) else $error("vms_cycle_sched: ROW_LINES must be at least 2");
      assert (ACTIVE_LINES > 0 && ACTIVE_LINES < FRAME_LINES)
         else $error("vms_cycle_sched: ACTIVE_LINES out of range");
      assert (REF_W >= 1 && REF_W <= 16) else $error("vms_cycle_sched: REF_W out of range");
      assert (LINES_PER_REF * LINE_SLOTS <= REF_PERIOD_SLOTS)
         else $error("vms_cycle_sched: refresh sweep exceeds REF_PERIOD_SLOTS");
   end

   logic       phase;
   logic       slot_first;
   logic       slot_active;
   line_kind_e line_kind;
   cyc_kind_e  fixed_kind;
   cyc_kind_e  cur_kind;
   logic       cpu_slot;
   logic       grant;
   logic       pend_q;

   vms_timebase #(
      .ACT_SLOTS    (ACT_SLOTS),
      .BLK_SLOTS    (BLK_SLOTS),
      .FRAME_LINES  (FRAME_LINES),
      .ACTIVE_LINES (ACTIVE_LINES),
      .ROW_LINES    (ROW_LINES)
   ) i_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .slot_first  (slot_first),
      .slot_active (slot_active),
      .line_kind   (line_kind)
   );

   vms_slot_decode i_decode (
      .phase       (phase),
      .slot_first  (slot_first),
      .slot_active (slot_active),
      .line_kind   (line_kind),
      .fixed_kind  (fixed_kind),
      .cpu_slot    (cpu_slot)
   );

   vms_cpu_gate i_cpu_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_slot (cpu_slot),
      .req      (cpu_req),
      .grant    (grant),
      .pend     (pend_q)
   );

   always_comb begin
      if (cpu_slot) cur_kind = grant ? CYC_CPU : CYC_DUMMY;
      else          cur_kind = fixed_kind;
   end

   vms_refresh_ctr #(.REF_W(REF_W)) i_refresh (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (cur_kind == CYC_REFRESH),
      .addr  (ref_addr)
   );

   assign cpu_grant = grant;
   assign cyc_type  = cur_kind;

endmodule

// File: rtl/vms_sched_checker.sv
module vms_sched_checker #(
   parameter int REF_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_grant,
   input logic [2:0]       cyc_type,
   input logic [REF_W-1:0] ref_addr,
   input logic             pend_q
);
   AST_GRANT_IS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_grant |-> (cyc_type == 3'd1)); // R4
   AST_CPU_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd1) |-> cpu_grant); // R4
   AST_ONE_GRANT_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_grant |=> !cpu_grant); // R4
   AST_REQ_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_grant) |=> pend_q); // R5
   AST_IDLE_CPU_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && !pend_q) |-> !cpu_grant); // R6
   AST_LOAD_THEN_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd4) |=> (cyc_type == 3'd3)); // R1
   AST_REFRESH_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd2) |=> (cyc_type == 3'd1 || cyc_type == 3'd0)); // R3
   AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd2) |=> (ref_addr == $past(ref_addr) + REF_W'(1))); // R7
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type != 3'd2) |=> $stable(ref_addr)); // R7
   AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_type <= 3'd4); // R1
endmodule

bind vms_cycle_sched vms_sched_checker #(.REF_W(REF_W)) i_sched_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_grant (cpu_grant),
   .cyc_type  (cyc_type),
   .ref_addr  (ref_addr),
   .pend_q    (pend_q)
);

// File: tb/test_vms_cycle_sched.sv
`timescale 1ns/1ps
module test_vms_cycle_sched;
   localparam int AS  = 4;
   localparam int BS  = 3;
   localparam int FL  = 26;
   localparam int AL  = 20;
   localparam int RL  = 5;
   localparam int RW  = 4;
   localparam int SPL = AS + BS;
   localparam int CYC_PER_FRAME = 2 * SPL * FL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0;
   logic          cpu_grant;
   logic [2:0]    cyc_type;
   logic [RW-1:0] ref_addr;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #10 clk = ~clk;

   vms_cycle_sched #(
      .ACT_SLOTS(AS), .BLK_SLOTS(BS), .FRAME_LINES(FL), .ACTIVE_LINES(AL),
      .ROW_LINES(RL), .REF_W(RW), .REF_PERIOD_SLOTS(64)
   ) i_vms_cycle_sched (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req),
      .cpu_grant(cpu_grant), .cyc_type(cyc_type), .ref_addr(ref_addr)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit req_pattern(input int n);
      int fr;
      fr = n / CYC_PER_FRAME;
      case (fr)
         0:       return (n % 11) == 3;
         1:       return 1'b1;
         2:       return (n % 37) == 0;
         default: return (n % 3) == 1;
      endcase
   endfunction

   initial begin
      bit pend_m;
      int ref_m;
      // R9: reset state
      #5;
      check("R9 type", cyc_type, 0);
      check("R9 grant", cpu_grant, 0);
      check("R9 ref_addr", ref_addr, 0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      pend_m = 1'b0;
      ref_m  = 0;
      for (int n = 0; n < 4 * CYC_PER_FRAME; n++) begin
         int ph, s, ln, row, exp_t;
         bit cslot, g, rq;
         string tag;
         ph  = n % 2;
         s   = (n / 2) % SPL;
         ln  = (n / (2 * SPL)) % FL;
         row = ln % RL;
         cslot = 1'b0;
         exp_t = 0;
         if (ln < AL && s < AS && (row == 0 || row == RL - 1)) begin
            tag   = "R1 R8 type";
            exp_t = (ph == 0) ? ((s == 0) ? 0 : 4) : 3;
         end else if (ln < AL && s < AS) begin
            tag = "R2 R8 type";
            if (ph == 0) exp_t = 3;
            else         cslot = 1'b1;
         end else begin
            tag = "R3 type";
            if (ph == 0) exp_t = 2;
            else         cslot = 1'b1;
         end
         rq = req_pattern(n);
         cpu_req = rq;
         g = cslot && (pend_m || rq);
         if (cslot) begin
            exp_t = g ? 1 : 0;
            if (!g) tag = "R6 idle CPU cycle type";
         end
         #1;
         check(tag, cyc_type, exp_t);
         check(cslot ? "R5 grant" : "R4 grant outside CPU cycle", cpu_grant, g);
         check("R7 ref_addr", ref_addr, ref_m);
         pend_m = (pend_m || rq) && !g;
         if (exp_t == 2) ref_m = (ref_m + 1) % (1 << RW);
         @(negedge clk);
      end
      cpu_req = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule